// File: doc/BRIEF.md
# Transfer Count and Reload Unit

This unit keeps the transfer counts for one channel of a data transfer controller. A 16-bit count register is loaded by software or by the channel sequencer. Each accepted transfer strobe steps it down. In normal mode the register is one 16-bit down-counter, and the unit signals the end of the transfer when the count runs out.

In repeat mode and block mode the register splits in two. The upper byte keeps a reload value. The lower byte is the working counter and is refilled from the upper byte each time it runs out. Repeat mode reports each refill as a wrap and runs without end. Block mode treats each refill as a finished block. A separate 16-bit block counter counts these blocks, and the transfer ends when it runs out.

In both counters a loaded zero stands for the largest count. The count register is written to the unit's parameter values, and a start strobe arms the unit. Outputs stay low until the unit is armed. The three output strobes and the two counter values are registered.

Top module: `xfer_count_unit`

## Requirements
- R1: After a synchronous reset, both `cnt_q` and `blk_q` read zero and `blk_boundary`, `rpt_wrap` and `xfer_end` are low.
- R2: Until a `start` strobe has armed the unit (it is armed from the cycle after `start`), `xfer` strobes leave `cnt_q` and `blk_q` unchanged and all three output strobes stay low.
- R3: Normal mode (`mode` 2'b00, and also 2'b11): each accepted `xfer` lowers the whole 16-bit `cnt_q` by one. When a transfer takes it from 1 to 0, `xfer_end` is high for exactly the following cycle and the unit disarms.
- R4: In normal mode a transfer at `cnt_q` = 0 gives 16'hFFFF with no `xfer_end`, so a loaded zero means 65536 transfers.
- R5: Repeat mode (2'b01) and block mode (2'b10): a transfer lowers `cnt_q[7:0]` by one and leaves `cnt_q[15:8]` alone. A transfer at `cnt_q[7:0]` = 1 loads `cnt_q[15:8]` into `cnt_q[7:0]` instead of zero.
- R6: In repeat and block modes a transfer at `cnt_q[7:0]` = 0 gives 8'hFF with no reload, so a lower-byte zero means 256 transfers.
- R7: In repeat mode, every reload raises `rpt_wrap` for exactly the next cycle. `xfer_end` never rises, and the unit stays armed.
- R8: In block mode every reload raises `blk_boundary` for the next cycle and lowers `blk_q` by one. A `blk_q` of 0 becomes 16'hFFFF, so zero means 65536 blocks.
- R9: In block mode, the reload that takes `blk_q` from 1 to 0 raises `xfer_end` together with `blk_boundary`, and the unit disarms.
- R10: A write in the same cycle as a transfer wins. With `cnt_wr`, `cnt_q` takes `cnt_wdata`, with no decrement and no strobe from the count register. With `blk_wr`, `blk_q` takes `blk_wdata` and skips its decrement, and `xfer_end` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Arms the unit from the next cycle |
| mode | input | 2 | 00 normal, 01 repeat, 10 block, 11 normal |
| cnt_wr | input | 1 | Load strobe for the count register |
| cnt_wdata | input | 16 | Count register load value |
| blk_wr | input | 1 | Load strobe for the block counter |
| blk_wdata | input | 16 | Block counter load value |
| xfer | input | 1 | One data unit transferred |
| cnt_q | output | 16 | Count register value |
| blk_q | output | 16 | Block counter value |
| blk_boundary | output | 1 | One-cycle pulse at each block end |
| rpt_wrap | output | 1 | One-cycle pulse at each repeat reload |
| xfer_end | output | 1 | One-cycle pulse when the transfer is finished |

## Verification
The hardest case to reach is a write that lands on the same edge as a transfer which would otherwise end the transfer or close a block. The stimulus first walks the counters to their last step. It then raises `xfer` and the write strobe in the same driven cycle, and checks that the written value survives and that no end pulse appears. The zero-means-maximum cases are reached directly, by loading zero and sending a single transfer.

// File: rtl/xfer_count_pkg.sv
package xfer_count_pkg;
  typedef enum logic [1:0] {
    XCU_NORMAL     = 2'b00,
    XCU_REPEAT     = 2'b01,
    XCU_BLOCK      = 2'b10,
    XCU_NORMAL_ALT = 2'b11
  } xcu_mode_e;
endpackage

// File: rtl/xcu_unit_counter.sv
module xcu_unit_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             step,
  input  logic             split,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap,
  output logic             full_end
);
  localparam int HALF_W = CNT_W / 2;

  logic [HALF_W-1:0] hi;
  logic [HALF_W-1:0] lo;
  logic              adv;

  assign hi  = cnt_q[CNT_W-1:HALF_W];
  assign lo  = cnt_q[HALF_W-1:0];
  assign adv = step & ~wr;

  // a lower byte at one reloads instead of reaching zero
  assign wrap     = adv & split & (lo == HALF_W'(1));
  assign full_end = adv & ~split & (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wr) begin
      cnt_q <= wdata;
    end else if (adv) begin
      if (split) begin
        cnt_q <= {hi, (lo == HALF_W'(1)) ? hi : lo - HALF_W'(1)};
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assert_reload_R5: assert property (@(posedge clk) disable iff (rst)
    (adv && split && lo == HALF_W'(1)) |=> (cnt_q[HALF_W-1:0] == $past(hi)));

  assert_upper_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (adv && split) |=> (cnt_q[CNT_W-1:HALF_W] == $past(hi)));

  assert_full_step_R3: assert property (@(posedge clk) disable iff (rst)
    (adv && !split) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
    wr |=> (cnt_q == $past(wdata)));
endmodule

// File: rtl/xcu_block_counter.sv
module xcu_block_counter #(
  parameter int BLK_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [BLK_W-1:0] wdata,
  input  logic             step,
  output logic [BLK_W-1:0] blk_q,
  output logic             last
);
  logic adv;
  assign adv  = step & ~wr;
  assign last = adv & (blk_q == BLK_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q <= '0;
    end else if (wr) begin
      blk_q <= wdata;
    end else if (adv) begin
      blk_q <= blk_q - BLK_W'(1);
    end
  end

  assert_blk_step_R8: assert property (@(posedge clk) disable iff (rst)
    adv |=> (blk_q == $past(blk_q) - BLK_W'(1)));

  assert_blk_write_R10: assert property (@(posedge clk) disable iff (rst)
    wr |=> (blk_q == $past(wdata)));
endmodule

// File: rtl/xfer_count_unit.sv
module xfer_count_unit
  import xfer_count_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BLK_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             blk_wr,
  input  logic [BLK_W-1:0] blk_wdata,
  input  logic             xfer,
  output logic [CNT_W-1:0] cnt_q,
  output logic [BLK_W-1:0] blk_q,
  output logic             blk_boundary,
  output logic             rpt_wrap,
  output logic             xfer_end
);
  xcu_mode_e md;
  logic      armed_q;
  logic      is_split;
  logic      unit_step;
  logic      wrap;
  logic      full_end;
  logic      blk_step;
  logic      blk_last;
  logic      done;

  assign md        = xcu_mode_e'(mode);
  assign is_split  = (md == XCU_REPEAT) || (md == XCU_BLOCK);
  assign unit_step = xfer & armed_q;
  assign blk_step  = wrap & (md == XCU_BLOCK);
  assign done      = full_end | blk_last;

  xcu_unit_counter #(.CNT_W(CNT_W)) u_unit (
    .clk      (clk),
    .rst      (rst),
    .wr       (cnt_wr),
    .wdata    (cnt_wdata),
    .step     (unit_step),
    .split    (is_split),
    .cnt_q    (cnt_q),
    .wrap     (wrap),
    .full_end (full_end)
  );

  xcu_block_counter #(.BLK_W(BLK_W)) u_blk (
    .clk   (clk),
    .rst   (rst),
    .wr    (blk_wr),
    .wdata (blk_wdata),
    .step  (blk_step),
    .blk_q (blk_q),
    .last  (blk_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q      <= 1'b0;
      rpt_wrap     <= 1'b0;
      blk_boundary <= 1'b0;
      xfer_end     <= 1'b0;
    end else begin
      armed_q      <= start | (armed_q & ~done);
      rpt_wrap     <= wrap & (md == XCU_REPEAT);
      blk_boundary <= blk_step;
      xfer_end     <= done;
    end
  end

  assert_quiet_unarmed_R2: assert property (@(posedge clk) disable iff (rst)
    !armed_q |=> (!xfer_end && !rpt_wrap && !blk_boundary));

  assert_repeat_no_end_R7: assert property (@(posedge clk) disable iff (rst)
    (md == XCU_REPEAT) |=> !xfer_end);

  assert_disarm_R9: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !armed_q);

  assert_excl_strobes_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rpt_wrap, blk_boundary}));
endmodule

// File: tb/xfer_count_unit_bench.sv
module xfer_count_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        cnt_wr = 1'b0;
  logic [15:0] cnt_wdata = '0;
  logic        blk_wr = 1'b0;
  logic [15:0] blk_wdata = '0;
  logic        xfer = 1'b0;
  logic [15:0] cnt_q;
  logic [15:0] blk_q;
  logic        blk_boundary;
  logic        rpt_wrap;
  logic        xfer_end;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  xfer_count_unit u_xfer_count_unit (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .blk_wr(blk_wr), .blk_wdata(blk_wdata), .xfer(xfer),
    .cnt_q(cnt_q), .blk_q(blk_q), .blk_boundary(blk_boundary),
    .rpt_wrap(rpt_wrap), .xfer_end(xfer_end)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic outs(input string tag, input logic b, input logic w, input logic e);
    chk({tag, " blk_boundary"}, 32'(blk_boundary), 32'(b));
    chk({tag, " rpt_wrap"}, 32'(rpt_wrap), 32'(w));
    chk({tag, " xfer_end"}, 32'(xfer_end), 32'(e));
  endtask

  task automatic ld_cnt(input logic [15:0] v);
    cnt_wr = 1'b1; cnt_wdata = v;
    @(negedge clk); cnt_wr = 1'b0;
  endtask

  task automatic ld_blk(input logic [15:0] v);
    blk_wr = 1'b1; blk_wdata = v;
    @(negedge clk); blk_wr = 1'b0;
  endtask

  task automatic arm();
    start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse();
    xfer = 1'b1;
    @(negedge clk); xfer = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cnt_q", 32'(cnt_q), 32'h0);
    chk("R1 blk_q", 32'(blk_q), 32'h0);
    outs("R1", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_unarmed();
    mode = 2'b00; ld_cnt(16'd5);
    for (int i = 0; i < 3; i++) pulse();
    chk("R2 cnt_q held", 32'(cnt_q), 32'd5);
    outs("R2", 1'b0, 1'b0, 1'b0);
    mode = 2'b10; ld_cnt(16'h0101); ld_blk(16'd1); pulse();
    chk("R2 block cnt_q held", 32'(cnt_q), 32'h0101);
    chk("R2 blk_q held", 32'(blk_q), 32'd1);
    outs("R2 block", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_normal();
    mode = 2'b00; ld_cnt(16'd3); arm();
    pulse(); chk("R3 cnt_q 2", 32'(cnt_q), 32'd2); outs("R3 step", 1'b0, 1'b0, 1'b0);
    pulse(); chk("R3 cnt_q 1", 32'(cnt_q), 32'd1);
    pulse(); chk("R3 cnt_q 0", 32'(cnt_q), 32'd0); outs("R3 end", 1'b0, 1'b0, 1'b1);
    @(negedge clk); outs("R3 end one cycle", 1'b0, 1'b0, 1'b0);
    pulse(); chk("R3 disarmed cnt_q", 32'(cnt_q), 32'd0);
    mode = 2'b11; ld_cnt(16'd2); arm();
    pulse(); pulse();
    chk("R3 mode11 cnt_q", 32'(cnt_q), 32'd0); outs("R3 mode11", 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_normal_zero();
    mode = 2'b00; ld_cnt(16'd0); arm(); pulse();
    chk("R4 zero to FFFF", 32'(cnt_q), 32'hFFFF);
    outs("R4", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_repeat();
    mode = 2'b01; ld_cnt(16'h0302); arm();
    pulse(); chk("R5 low step", 32'(cnt_q), 32'h0301); outs("R5 step", 1'b0, 1'b0, 1'b0);
    pulse(); chk("R5 reload", 32'(cnt_q), 32'h0303); outs("R7 wrap", 1'b0, 1'b1, 1'b0);
    @(negedge clk); outs("R7 wrap one cycle", 1'b0, 1'b0, 1'b0);
    pulse(); pulse(); chk("R5 low 1", 32'(cnt_q), 32'h0301);
    pulse(); chk("R7 second reload", 32'(cnt_q), 32'h0303); outs("R7 again", 1'b0, 1'b1, 1'b0);
    pulse(); chk("R7 still armed", 32'(cnt_q), 32'h0302);
  endtask

  task automatic t_low_zero();
    mode = 2'b01; ld_cnt(16'h0500); arm(); pulse();
    chk("R6 low zero to FF", 32'(cnt_q), 32'h05FF);
    outs("R6", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_block();
    mode = 2'b10; ld_cnt(16'h0202); ld_blk(16'd2); arm();
    pulse(); chk("R5 block step", 32'(cnt_q), 32'h0201); chk("R8 blk held", 32'(blk_q), 32'd2);
    pulse(); chk("R8 reload", 32'(cnt_q), 32'h0202); chk("R8 blk dec", 32'(blk_q), 32'd1);
    outs("R8 boundary", 1'b1, 1'b0, 1'b0);
    pulse(); pulse();
    chk("R9 blk zero", 32'(blk_q), 32'd0); outs("R9 end", 1'b1, 1'b0, 1'b1);
    pulse(); chk("R9 disarmed cnt_q", 32'(cnt_q), 32'h0201 + 32'h1);
    outs("R9 disarmed", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_block_zero();
    mode = 2'b10; ld_cnt(16'h0101); ld_blk(16'd0); arm(); pulse();
    chk("R8 blk zero to FFFF", 32'(blk_q), 32'hFFFF);
    outs("R8 zero", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_priority();
    mode = 2'b00; ld_cnt(16'd1); arm();
    xfer = 1'b1; cnt_wr = 1'b1; cnt_wdata = 16'd9;
    @(negedge clk); xfer = 1'b0; cnt_wr = 1'b0;
    chk("R10 cnt write wins", 32'(cnt_q), 32'd9); outs("R10 cnt", 1'b0, 1'b0, 1'b0);
    pulse(); chk("R10 armed after", 32'(cnt_q), 32'd8);
    mode = 2'b10; ld_cnt(16'h0101); ld_blk(16'd1); arm();
    xfer = 1'b1; blk_wr = 1'b1; blk_wdata = 16'd7;
    @(negedge clk); xfer = 1'b0; blk_wr = 1'b0;
    chk("R10 blk write wins", 32'(blk_q), 32'd7);
    outs("R10 blk", 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_unarmed();
    t_normal();
    t_normal_zero();
    t_repeat();
    t_low_zero();
    t_block();
    t_block_zero();
    t_priority();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule